// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves translation-buffer misses without software help. A miss arrives carrying a virtual page number, an address-space tag and the kind of access that failed. The walker forms the address of the matching entry in a single-level linear page table from a base register, reads that one 32-bit entry over a simple request/valid memory port, and judges it.

If the entry is absent, or present but not permitting the access, the walker raises a fault code. The code stays on the outputs until the requester acknowledges it. Otherwise the walker writes the translation into the translation buffer for one cycle and then pulses a retry signal, so the faulting access can be replayed. Only one walk is ever in flight. A new miss is taken only while the walker is idle.

Entry layout, by bit position: bit 31 is present, bits 30:28 are permissions (bit 28 read, bit 29 write, bit 30 execute), bit 27 marks a page shared by all address spaces, bits 26:24 are unused and bits 23:0 hold the frame number. Access type encoding is 0 load, 1 store, 2 instruction fetch and 3 reserved.

Top module: `pt_walker`

## Requirements
- R1: The entry is read at address {ptbr[31:2], 2'b00} + vpn * 4; the two low bits of the base input are ignored.
- R2: Exactly one memory request pulse is issued per walk, in the cycle after the miss is accepted; the walker then waits any number of cycles for mem_rvalid without producing a result.
- R3: miss_ready is high only while idle; a miss presented while a walk is in progress is ignored and does not alter the walk's page number or address-space tag.
- R4: An entry whose present bit (31) is clear gives fault code 1, with no translation-buffer write and no retry.
- R5: A present entry whose permission bit for the access is clear (bit 28 load, bit 29 store, bit 30 fetch) gives fault code 2, with no write and no retry.
- R6: The present bit is judged before the permissions: an absent entry that also forbids the access reports code 1.
- R7: A permitted access gives exactly one tlb_wr pulse, carrying the walk's page number and tag, frame number bits 23:0, permission bits 30:28 and the shared bit 27 of the entry.
- R8: retry is a single-cycle pulse in the cycle directly after tlb_wr, and it never appears after a fault.
- R9: fault_valid and fault_code stay asserted and unchanged until the cycle fault_ack is seen, including an acknowledge in the first fault cycle; fault_code reads 0 when no fault is shown.
- R10: After reset, miss_ready is 1 and mem_req, tlb_wr, retry and fault_valid are 0.
- R11: Access type 3 is never permitted and always gives fault code 2 on a present entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle and able to accept a miss |
| miss_vpn | input | VPN_W | Virtual page number of the miss |
| miss_asid | input | ASID_W | Address-space tag of the miss |
| miss_access | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| ptbr | input | PA_W | Page-table base address |
| mem_req | output | 1 | Single-cycle entry read request |
| mem_addr | output | PA_W | Entry read address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Page-table entry |
| tlb_wr | output | 1 | Translation-buffer write strobe |
| tlb_vpn | output | VPN_W | Page number to install |
| tlb_asid | output | ASID_W | Address-space tag to install |
| tlb_pfn | output | 24 | Frame number to install |
| tlb_prot | output | 3 | Permission bits to install |
| tlb_global | output | 1 | Shared-page flag to install |
| retry | output | 1 | Replay the faulting access |
| fault_valid | output | 1 | Fault presented |
| fault_code | output | 2 | 0 none, 1 absent, 2 permission |
| fault_ack | input | 1 | Fault acknowledge |

## Verification
Two events can fall in the same cycle. A new miss can be presented while the previous walk is still finishing, and an acknowledge can arrive in the very cycle a fault is first shown. The bench holds miss_valid high with a different page number for the whole of a walk, retry cycle included. It judges that only one memory request appears and that the installed page number is the original one. In a separate test it acknowledges a fault on the first fault cycle, and it checks that the walker leaves the fault after exactly one cycle and issues no retry.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int PTE_W  = 32;
    localparam int PFN_W  = 24;
    localparam int PROT_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_CHECK,
        ST_FILL,
        ST_FAULT,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ABSENT  = 2'd1,
        FLT_PERM    = 2'd2
    } fault_e;

    // Entry image: bit 31 present, 30:28 permissions, 27 shared, 23:0 frame
    typedef struct packed {
        logic              present;
        logic [PROT_W-1:0] perm;
        logic              shared;
        logic [2:0]        spare;
        logic [PFN_W-1:0]  frame;
    } pte_t;

    // perm[0] read, perm[1] write, perm[2] execute
    function automatic logic perm_allows(logic [PROT_W-1:0] perm, access_e acc);
        logic ok;
        case (acc)
            ACC_LOAD:  ok = perm[0];
            ACC_STORE: ok = perm[1];
            ACC_FETCH: ok = perm[2];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int VPN_W = 20,
    parameter int PA_W  = 32
) (
    input  logic [PA_W-1:0]  base_i,
    input  logic [VPN_W-1:0] vpn_i,
    output logic [PA_W-1:0]  addr_o
);
    localparam int OFF_W = VPN_W + 2;

    logic [PA_W-1:0] aligned_base;
    logic [PA_W-1:0] offset;
    logic [1:0]      unused_base_lo;

    assign aligned_base   = {base_i[PA_W-1:2], 2'b00};
    assign unused_base_lo = base_i[1:0];

    generate
        if (PA_W >= OFF_W) begin : g_pad
            if (PA_W > OFF_W) begin : g_wide
                assign offset = {{(PA_W-OFF_W){1'b0}}, vpn_i, 2'b00};
            end else begin : g_exact
                assign offset = {vpn_i, 2'b00};
            end
        end else begin : g_trunc
            logic [OFF_W-1:0] full_off;
            logic [OFF_W-PA_W-1:0] unused_off_hi;
            assign full_off      = {vpn_i, 2'b00};
            assign offset        = full_off[PA_W-1:0];
            assign unused_off_hi = full_off[OFF_W-1:PA_W];
        end
    endgenerate

    assign addr_o = aligned_base + offset;

endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
    import pt_walker_pkg::*;
(
    input  pte_t    pte_i,
    input  access_e access_i,
    output fault_e  verdict_o
);
    // Presence is judged first, permissions second.
    always_comb begin
        if (!pte_i.present)
            verdict_o = FLT_ABSENT;
        else if (!perm_allows(pte_i.perm, access_i))
            verdict_o = FLT_PERM;
        else
            verdict_o = FLT_NONE;
    end

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walker_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   miss_valid_i,
    input  logic   mem_rvalid_i,
    input  fault_e verdict_i,
    input  logic   fault_ack_i,
    output logic   miss_ready_o,
    output logic   accept_o,
    output logic   mem_req_o,
    output logic   pte_load_o,
    output logic   tlb_wr_o,
    output logic   retry_o,
    output logic   fault_valid_o,
    output fault_e fault_code_o
);
    walk_state_e state_q;
    logic        filled_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            filled_q     <= 1'b0;
            fault_code_o <= FLT_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    filled_q <= 1'b0;
                    if (miss_valid_i) state_q <= ST_REQ;
                end
                ST_REQ:  state_q <= ST_WAIT;
                ST_WAIT: if (mem_rvalid_i) state_q <= ST_CHECK;
                ST_CHECK: begin
                    if (verdict_i == FLT_NONE) begin
                        state_q <= ST_FILL;
                    end else begin
                        state_q      <= ST_FAULT;
                        fault_code_o <= verdict_i;
                    end
                end
                ST_FILL: begin
                    filled_q <= 1'b1;
                    state_q  <= ST_DONE;
                end
                ST_FAULT: begin
                    if (fault_ack_i) begin
                        fault_code_o <= FLT_NONE;
                        state_q      <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign miss_ready_o  = (state_q == ST_IDLE);
    assign accept_o      = miss_ready_o && miss_valid_i;
    assign mem_req_o     = (state_q == ST_REQ);
    assign pte_load_o    = (state_q == ST_WAIT) && mem_rvalid_i;
    assign tlb_wr_o      = (state_q == ST_FILL);
    assign retry_o       = (state_q == ST_DONE) && filled_q;
    assign fault_valid_o = (state_q == ST_FAULT);

    AST_REQ_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> mem_req_o); // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o || tlb_wr_o || fault_valid_o || retry_o) |-> !miss_ready_o); // R3
    AST_FAULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (fault_valid_o && !fault_ack_i) |=> (fault_valid_o && $stable(fault_code_o))); // R9
    AST_RETRY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        tlb_wr_o |=> retry_o); // R8
    AST_RETRY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        retry_o |-> $past(tlb_wr_o)); // R8
    AST_WRITE_XOR_FAULT: assert property (@(posedge clk) disable iff (rst)
        !(tlb_wr_o && fault_valid_o)); // R4

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PA_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [ASID_W-1:0] miss_asid,
    input  logic [1:0]        miss_access,
    input  logic [PA_W-1:0]   ptbr,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [PTE_W-1:0]  mem_rdata,
    output logic              tlb_wr,
    output logic [VPN_W-1:0]  tlb_vpn,
    output logic [ASID_W-1:0] tlb_asid,
    output logic [PFN_W-1:0]  tlb_pfn,
    output logic [PROT_W-1:0] tlb_prot,
    output logic              tlb_global,
    output logic              retry,
    output logic              fault_valid,
    output logic [1:0]        fault_code,
    input  logic              fault_ack
);
    logic              accept;
    logic              pte_load;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    access_e           acc_q;
    pte_t              pte_q;
    fault_e            verdict;
    fault_e            code_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            vpn_q  <= '0;
            asid_q <= '0;
            acc_q  <= ACC_LOAD;
            pte_q  <= '0;
        end else begin
            if (accept) begin
                vpn_q  <= miss_vpn;
                asid_q <= miss_asid;
                acc_q  <= access_e'(miss_access);
            end
            if (pte_load) pte_q <= pte_t'(mem_rdata);
        end
    end

    pt_addr_gen #(
        .VPN_W (VPN_W),
        .PA_W  (PA_W)
    ) u_addr (
        .base_i (ptbr),
        .vpn_i  (vpn_q),
        .addr_o (mem_addr)
    );

    pt_entry_check u_check (
        .pte_i     (pte_q),
        .access_i  (acc_q),
        .verdict_o (verdict)
    );

    pt_walk_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .miss_valid_i  (miss_valid),
        .mem_rvalid_i  (mem_rvalid),
        .verdict_i     (verdict),
        .fault_ack_i   (fault_ack),
        .miss_ready_o  (miss_ready),
        .accept_o      (accept),
        .mem_req_o     (mem_req),
        .pte_load_o    (pte_load),
        .tlb_wr_o      (tlb_wr),
        .retry_o       (retry),
        .fault_valid_o (fault_valid),
        .fault_code_o  (code_e)
    );

    assign fault_code = code_e;
    assign tlb_vpn    = vpn_q;
    assign tlb_asid   = asid_q;
    assign tlb_pfn    = pte_q.frame;
    assign tlb_prot   = pte_q.perm;
    assign tlb_global = pte_q.shared;

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R1
    AST_FILL_PRESENT: assert property (@(posedge clk) disable iff (rst)
        tlb_wr |-> pte_q.present); // R7
    AST_CODE_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !fault_valid |-> (fault_code == 2'd0)); // R9

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_valid = 1'b0;
    logic        miss_ready;
    logic [19:0] miss_vpn = '0;
    logic [7:0]  miss_asid = '0;
    logic [1:0]  miss_access = '0;
    logic [31:0] ptbr = 32'h8000_1003;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tlb_wr;
    logic [19:0] tlb_vpn;
    logic [7:0]  tlb_asid;
    logic [23:0] tlb_pfn;
    logic [2:0]  tlb_prot;
    logic        tlb_global;
    logic        retry;
    logic        fault_valid;
    logic [1:0]  fault_code;
    logic        fault_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_vpn(miss_vpn), .miss_asid(miss_asid), .miss_access(miss_access),
        .ptbr(ptbr),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tlb_wr(tlb_wr), .tlb_vpn(tlb_vpn), .tlb_asid(tlb_asid),
        .tlb_pfn(tlb_pfn), .tlb_prot(tlb_prot), .tlb_global(tlb_global),
        .retry(retry), .fault_valid(fault_valid), .fault_code(fault_code),
        .fault_ack(fault_ack)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One complete walk with bench-computed expectations.
    task automatic walk(input string tag, input logic [19:0] vpn,
                        input logic [7:0] asid, input logic [1:0] acc,
                        input logic [31:0] pte, input int lat,
                        input int ackdly, input bit hold);
        logic        ok;
        logic [1:0]  exp_code;
        logic [31:0] exp_addr;
        int          extra_req = 0, ready_hi = 0, early = 0;
        int          wr_cnt = 0, wr_at = -10, rt_cnt = 0, rt_at = -10;
        int          fcycles = 0;
        bit          fseen = 0, unstable = 0;
        logic [1:0]  fcode = 0;
        logic [19:0] w_vpn = 0; logic [7:0] w_asid = 0;
        logic [23:0] w_pfn = 0; logic [2:0] w_prot = 0; logic w_glob = 0;

        case (acc)
            2'd0: ok = pte[28];
            2'd1: ok = pte[29];
            2'd2: ok = pte[30];
            default: ok = 1'b0;
        endcase
        exp_code = !pte[31] ? 2'd1 : (!ok ? 2'd2 : 2'd0);
        exp_addr = {ptbr[31:2], 2'b00} + {10'd0, vpn, 2'b00};

        @(negedge clk);
        miss_valid = 1'b1; miss_vpn = vpn; miss_asid = asid; miss_access = acc;
        @(negedge clk);
        if (hold) begin
            miss_vpn = ~vpn; miss_asid = ~asid;
        end else begin
            miss_valid = 1'b0;
        end
        check("R2", {tag, " request after accept"}, mem_req, 1);
        check("R1", {tag, " entry address"}, mem_addr, exp_addr);
        for (int k = 0; k <= lat; k++) begin
            @(negedge clk);
            if (mem_req) extra_req++;
            if (miss_ready) ready_hi++;
            if (tlb_wr || fault_valid || retry) early++;
        end
        mem_rvalid = 1'b1; mem_rdata = pte;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        for (int i = 0; i < 40; i++) begin
            if (mem_req) extra_req++;
            if (tlb_wr) begin
                wr_cnt++; wr_at = i;
                w_vpn = tlb_vpn; w_asid = tlb_asid; w_pfn = tlb_pfn;
                w_prot = tlb_prot; w_glob = tlb_global;
            end
            if (retry) begin rt_cnt++; rt_at = i; end
            if (fault_valid) begin
                if (!fseen) begin fseen = 1; fcode = fault_code; end
                else if (fault_code !== fcode) unstable = 1;
                fault_ack = (fcycles == ackdly);
                fcycles++;
            end else begin
                fault_ack = 1'b0;
            end
            if (miss_ready) break;
            @(negedge clk);
        end
        miss_valid = 1'b0; fault_ack = 1'b0;

        check("R2", {tag, " single request per walk"}, extra_req, 0);
        check("R2", {tag, " nothing before data"}, early, 0);
        check("R3", {tag, " not ready while busy"}, ready_hi, 0);
        check(tag, {tag, " fault code"}, fseen ? fcode : 2'd0, exp_code);
        if (exp_code == 2'd0) begin
            check("R7", {tag, " one write"}, wr_cnt, 1);
            check("R7", {tag, " written vpn"}, w_vpn, vpn);
            check("R7", {tag, " written asid"}, w_asid, asid);
            check("R7", {tag, " written frame"}, w_pfn, pte[23:0]);
            check("R7", {tag, " written perm"}, w_prot, pte[30:28]);
            check("R7", {tag, " written shared"}, w_glob, pte[27]);
            check("R8", {tag, " one retry"}, rt_cnt, 1);
            check("R8", {tag, " retry follows write"}, rt_at, wr_at + 1);
        end else begin
            check(tag, {tag, " no write on fault"}, wr_cnt, 0);
            check("R8", {tag, " no retry on fault"}, rt_cnt, 0);
            check("R9", {tag, " fault held until ack"}, fcycles, ackdly + 1);
            check("R9", {tag, " code stable"}, unstable, 0);
        end
        check("R9", {tag, " code cleared after"}, fault_code, 0);
    endtask

    task automatic t_reset();
        check("R10", "ready after reset", miss_ready, 1);
        check("R10", "no request after reset", mem_req, 0);
        check("R10", "no write after reset", tlb_wr, 0);
        check("R10", "no retry after reset", retry, 0);
        check("R10", "no fault after reset", fault_valid, 0);
    endtask

    task automatic t_load_ok();      walk("R7", 20'h00012, 8'h3C, 2'd0, 32'h9000_0ABC, 0, 0, 0); endtask
    task automatic t_store_shared(); walk("R7", 20'h0BEEF, 8'h01, 2'd1, 32'hA800_1234, 3, 0, 0); endtask
    task automatic t_fetch_ok();     walk("R7", 20'h54321, 8'hF0, 2'd2, 32'hC0FF_FFFF, 1, 0, 0); endtask
    task automatic t_store_denied(); walk("R5", 20'h00100, 8'h22, 2'd1, 32'hD800_0055, 2, 2, 0); endtask
    task automatic t_fetch_denied(); walk("R5", 20'h00101, 8'h22, 2'd2, 32'hB000_0055, 0, 1, 0); endtask
    task automatic t_absent();       walk("R4", 20'h00777, 8'h09, 2'd0, 32'h7000_0099, 1, 0, 0); endtask
    task automatic t_absent_denied();walk("R6", 20'h00778, 8'h09, 2'd1, 32'h0000_0099, 0, 3, 0); endtask
    task automatic t_reserved_acc(); walk("R11", 20'h00200, 8'h44, 2'd3, 32'hF800_0001, 0, 0, 0); endtask
    task automatic t_vpn_top();      walk("R1", 20'hFFFFF, 8'hFF, 2'd0, 32'h9012_3456, 5, 0, 0); endtask
    task automatic t_busy_ignored(); walk("R3", 20'h0A5A5, 8'h5A, 2'd0, 32'h9000_0001, 4, 0, 1); endtask
    task automatic t_fault_busy();   walk("R3", 20'h0A5A6, 8'h5A, 2'd1, 32'h1000_0001, 2, 2, 1); endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_ok();
        t_store_shared();
        t_fetch_ok();
        t_store_denied();
        t_fetch_denied();
        t_absent();
        t_absent_denied();
        t_reserved_acc();
        ptbr = 32'h0010_0002;
        t_vpn_top();
        t_busy_ignored();
        t_fault_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule